// File: doc/BRIEF.md
# Four-Level Address Pin Decoder

This block works out how each of two address-select pins is connected on the board: to ground, to the supply, to the serial clock line or to the serial data line. It builds the low four bits of a 7-bit bus slave address from those four-way choices, and it drives one pullup enable for each group of four input ports. The inputs are the serial clock and data lines, already synchronized to the core clock, the two pin levels, and a transmission-active window from the bus monitor. The upper three address bits are fixed at 110, so the address lies between 0x60 and 0x6F.

While the window is open, the block compares each pin with both bus lines. If a pin follows the clock line through the whole window, it is classed as clock-tied. If it follows the data line, it is classed as data-tied. Otherwise it keeps the last level it had. The result is committed when the window closes, and it is worked out again on every transmission, whichever device that transmission addresses. Until the first window has closed after reset, a pin tied to a bus line cannot be told from a static level. Each field therefore simply shows the pin's current level.

Top module: `addr_pin_decoder`

## Requirements
- R1: `addr[6:4]` is always 3'b110.
- R2: From reset until the first window closes, each pin's address field is 2'b0 followed by the pin's current level. Pin 1 sets `addr[3:2]`, pin 0 sets `addr[1:0]`, and the field follows the pin within the same cycle.
- R3: At window close, the field is 2'b10 (clock-tied) when three things held over every sampled window cycle: the pin equalled `scl`, the pin was seen both high and low, and `scl` differed from `sda` at least once.
- R4: At window close, the field is 2'b11 (data-tied) under the same rule with `sda` in place of `scl`.
- R5: Otherwise the field is 2'b00 when the pin was low in the last sampled window cycle (ground), or 2'b01 when it was high (supply).
- R6: A window cycle is a rising clock edge with `xfer_active` high. The new fields appear right after the first rising edge that samples `xfer_active` low following a high. Once a result exists, `addr` changes at no other time, whatever the pins and bus lines do.
- R7: Each window is classified afresh and replaces the previous result. There is no address comparison, so a window addressed to any device re-decodes the pins.
- R8: `pu_en[0]` is driven by pin 0 and covers ports 3..0. `pu_en[1]` is driven by pin 1 and covers ports 7..4. Each is 1 unless its pin's field is 2'b00.
- R9: Asserting `rst_n` low discards the result and returns to the behaviour of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Synchronized serial clock line |
| sda | input | 1 | Synchronized serial data line |
| xfer_active | input | 1 | High while a bus transmission is in progress |
| tie_pin | input | 2 | Synchronized address-select pin levels; bit 1 sets A3:A2, bit 0 sets A1:A0 |
| addr | output | 7 | Decoded slave address |
| pu_en | output | 2 | Pullup enable; bit 1 for ports 7..4, bit 0 for ports 3..0 |

## Verification
Before the first window closes, the fields follow the pins in the same cycle. The bench checks them one time unit after it changes a pin, away from any clock edge. A window result is due right after the first rising edge that samples `xfer_active` low following a high. The bench lowers `xfer_active` on a falling edge, lets exactly one rising edge pass, and compares at the next falling edge. Inside a window, and between windows, every falling edge checks that a committed `addr` has not moved. After each window, the expected codes come from a bench model that follows each pin's match, toggle and split history cycle by cycle.

// File: rtl/addr_dec_pkg.sv
`timescale 1ns/1ps
package addr_dec_pkg;

   localparam int TIE_CODE_W = 2;

   typedef enum logic [TIE_CODE_W-1:0] {
      TIE_GND    = 2'b00,
      TIE_SUPPLY = 2'b01,
      TIE_SCL    = 2'b10,
      TIE_SDA    = 2'b11
   } tie_code_e;

   // Final verdict for one pin from its window history.
   function automatic tie_code_e resolve_tie(
      input logic followed_scl,
      input logic followed_sda,
      input logic saw_high,
      input logic saw_low,
      input logic lines_split,
      input logic last_level
   );
      logic toggled;
      toggled = saw_high & saw_low;
      if (followed_scl && toggled && lines_split)
         return TIE_SCL;
      else if (followed_sda && toggled && lines_split)
         return TIE_SDA;
      else if (last_level)
         return TIE_SUPPLY;
      else
         return TIE_GND;
   endfunction

endpackage

// File: rtl/bus_window_tracker.sv
`timescale 1ns/1ps
module bus_window_tracker (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   input  logic xfer_active,
   output logic win_close,
   output logic lines_split,
   output logic resolved
);

   logic act_q;
   logic split_q;
   logic resolved_q;

   assign win_close   = act_q & ~xfer_active;
   assign lines_split = split_q;
   assign resolved    = resolved_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q      <= 1'b0;
         split_q    <= 1'b0;
         resolved_q <= 1'b0;
      end else begin
         act_q <= xfer_active;
         if (win_close) begin
            split_q    <= 1'b0;
            resolved_q <= 1'b1;
         end else if (xfer_active && (scl != sda)) begin
            split_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/tie_classifier.sv
`timescale 1ns/1ps
module tie_classifier
   import addr_dec_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl,
   input  logic                  sda,
   input  logic                  xfer_active,
   input  logic                  win_close,
   input  logic                  lines_split,
   input  logic                  resolved,
   input  logic                  pin,
   output logic [TIE_CODE_W-1:0] code
);

   logic      follow_scl_q;
   logic      follow_sda_q;
   logic      saw_high_q;
   logic      saw_low_q;
   logic      last_lvl_q;
   tie_code_e code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         follow_scl_q <= 1'b1;
         follow_sda_q <= 1'b1;
         saw_high_q   <= 1'b0;
         saw_low_q    <= 1'b0;
         last_lvl_q   <= 1'b0;
         code_q       <= TIE_GND;
      end else if (win_close) begin
         code_q       <= resolve_tie(follow_scl_q, follow_sda_q, saw_high_q,
                                     saw_low_q, lines_split, last_lvl_q);
         follow_scl_q <= 1'b1;
         follow_sda_q <= 1'b1;
         saw_high_q   <= 1'b0;
         saw_low_q    <= 1'b0;
      end else if (xfer_active) begin
         follow_scl_q <= follow_scl_q & (pin == scl);
         follow_sda_q <= follow_sda_q & (pin == sda);
         saw_high_q   <= saw_high_q | pin;
         saw_low_q    <= saw_low_q | ~pin;
         last_lvl_q   <= pin;
      end
   end

   // Before any result exists a pin is only visible as a static level.
   always_comb begin
      if (resolved)
         code = code_q;
      else
         code = {1'b0, pin};
   end

endmodule

// File: rtl/addr_assembler.sv
`timescale 1ns/1ps
module addr_assembler
   import addr_dec_pkg::*;
#(
   parameter int                  PIN_COUNT = 2,
   parameter int                  PREFIX_W  = 3,
   parameter logic [PREFIX_W-1:0] PREFIX    = 3'b110,
   localparam int                 CODES_W   = PIN_COUNT * TIE_CODE_W,
   localparam int                 ADDR_W    = PREFIX_W + CODES_W
) (
   input  logic [CODES_W-1:0]   codes,
   output logic [ADDR_W-1:0]    addr,
   output logic [PIN_COUNT-1:0] pu_en
);

   assign addr = {PREFIX, codes};

   for (genvar g = 0; g < PIN_COUNT; g++) begin : g_pullup
      // Ground tie is the only choice that leaves the group without pullups.
      assign pu_en[g] = (codes[g*TIE_CODE_W +: TIE_CODE_W] != TIE_GND);
   end

endmodule

// File: rtl/addr_pin_decoder.sv
`timescale 1ns/1ps
module addr_pin_decoder
   import addr_dec_pkg::*;
#(
   parameter int                  PIN_COUNT = 2,
   parameter int                  PREFIX_W  = 3,
   parameter logic [PREFIX_W-1:0] PREFIX    = 3'b110,
   localparam int                 CODES_W   = PIN_COUNT * TIE_CODE_W,
   localparam int                 ADDR_W    = PREFIX_W + CODES_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scl,
   input  logic                 sda,
   input  logic                 xfer_active,
   input  logic [PIN_COUNT-1:0] tie_pin,
   output logic [ADDR_W-1:0]    addr,
   output logic [PIN_COUNT-1:0] pu_en
);

   if (PIN_COUNT < 1) begin : g_bad_pins
      $error("addr_pin_decoder: PIN_COUNT must be at least 1");
   end
   if (PREFIX_W < 1) begin : g_bad_prefix
      $error("addr_pin_decoder: PREFIX_W must be at least 1");
   end
   if (ADDR_W > 10) begin : g_bad_addr
      $error("addr_pin_decoder: address wider than 10 bits");
   end

   logic               win_close;
   logic               lines_split;
   logic               resolved;
   logic [CODES_W-1:0] codes;

   bus_window_tracker i_window (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl         (scl),
      .sda         (sda),
      .xfer_active (xfer_active),
      .win_close   (win_close),
      .lines_split (lines_split),
      .resolved    (resolved)
   );

   for (genvar g = 0; g < PIN_COUNT; g++) begin : g_pin
      tie_classifier i_class (
         .clk         (clk),
         .rst_n       (rst_n),
         .scl         (scl),
         .sda         (sda),
         .xfer_active (xfer_active),
         .win_close   (win_close),
         .lines_split (lines_split),
         .resolved    (resolved),
         .pin         (tie_pin[g]),
         .code        (codes[g*TIE_CODE_W +: TIE_CODE_W])
      );
   end

   addr_assembler #(
      .PIN_COUNT (PIN_COUNT),
      .PREFIX_W  (PREFIX_W),
      .PREFIX    (PREFIX)
   ) i_assemble (
      .codes (codes),
      .addr  (addr),
      .pu_en (pu_en)
   );

endmodule

// File: rtl/addr_pin_decoder_chk.sv
`timescale 1ns/1ps
module addr_pin_decoder_chk #(
   parameter int                  PIN_COUNT = 2,
   parameter int                  PREFIX_W  = 3,
   parameter logic [PREFIX_W-1:0] PREFIX    = 3'b110,
   parameter int                  ADDR_W    = 7
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 xfer_active,
   input logic [PIN_COUNT-1:0] tie_pin,
   input logic [ADDR_W-1:0]    addr,
   input logic [PIN_COUNT-1:0] pu_en
);

   logic act_d;
   logic seen_end_q;
   logic end_now;

   assign end_now = act_d & ~xfer_active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_d      <= 1'b0;
         seen_end_q <= 1'b0;
      end else begin
         act_d <= xfer_active;
         if (end_now) seen_end_q <= 1'b1;
      end
   end

   assert_fixed_prefix_R1: assert property (@(posedge clk) disable iff (!rst_n)
      addr[ADDR_W-1 -: PREFIX_W] == PREFIX);

   assert_hold_between_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_end_q && !end_now) |=> $stable(addr));

   for (genvar g = 0; g < PIN_COUNT; g++) begin : g_pin_chk
      assert_live_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !seen_end_q |-> (addr[2*g +: 2] == {1'b0, tie_pin[g]}));

      assert_pullup_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
         pu_en[g] == (addr[2*g +: 2] != 2'b00));
   end

endmodule

bind addr_pin_decoder addr_pin_decoder_chk #(
   .PIN_COUNT (PIN_COUNT),
   .PREFIX_W  (PREFIX_W),
   .PREFIX    (PREFIX),
   .ADDR_W    (ADDR_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .xfer_active (xfer_active),
   .tie_pin     (tie_pin),
   .addr        (addr),
   .pu_en       (pu_en)
);

// File: tb/test_addr_pin_decoder.sv
`timescale 1ns/1ps
module test_addr_pin_decoder;

   localparam int PINS = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            scl = 1'b1;
   logic            sda = 1'b1;
   logic            xfer_active = 1'b0;
   logic [PINS-1:0] tie_pin = '0;
   logic [6:0]      addr;
   logic [PINS-1:0] pu_en;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // Bench model state
   bit       m_resolved;
   bit [1:0] m_code [PINS];
   bit       m_fs [PINS];
   bit       m_fd [PINS];
   bit       m_hi [PINS];
   bit       m_lo [PINS];
   bit       m_lv [PINS];
   bit       m_split;

   always #2.5 clk = ~clk;

   addr_pin_decoder i_addr_pin_decoder (
      .clk (clk), .rst_n (rst_n), .scl (scl), .sda (sda),
      .xfer_active (xfer_active), .tie_pin (tie_pin),
      .addr (addr), .pu_en (pu_en)
   );

   function automatic logic pin_of(input int tie, input logic s, input logic d);
      case (tie)
         0: return 1'b0;
         1: return 1'b1;
         2: return s;
         default: return d;
      endcase
   endfunction

   function automatic logic [6:0] exp_addr();
      logic [1:0] f1, f0;
      f1 = m_resolved ? m_code[1] : {1'b0, tie_pin[1]};
      f0 = m_resolved ? m_code[0] : {1'b0, tie_pin[0]};
      return {3'b110, f1, f0};
   endfunction

   function automatic logic [1:0] exp_pu();
      logic [6:0] a;
      a = exp_addr();
      return {a[3:2] != 2'b00, a[1:0] != 2'b00};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < PINS; i++) begin
         m_fs[i] = 1'b1; m_fd[i] = 1'b1; m_hi[i] = 1'b0; m_lo[i] = 1'b0;
      end
      m_split = 1'b0;
   endtask

   task automatic model_reset();
      m_resolved = 1'b0;
      for (int i = 0; i < PINS; i++) begin
         m_code[i] = 2'b00; m_lv[i] = 1'b0;
      end
      model_clear();
   endtask

   // Drive one window cycle at a falling edge; the next rising edge samples it.
   task automatic win_cycle(input logic s, input logic d, input logic [1:0] p);
      check("R6 addr steady inside window", addr, exp_addr());
      xfer_active = 1'b1; scl = s; sda = d; tie_pin = p;
      for (int i = 0; i < PINS; i++) begin
         m_fs[i] &= (p[i] == s);
         m_fd[i] &= (p[i] == d);
         m_hi[i] |= p[i];
         m_lo[i] |= ~p[i];
         m_lv[i]  = p[i];
      end
      if (s != d) m_split = 1'b1;
      @(negedge clk);
   endtask

   // Close the window; one rising edge commits, checked at the next falling edge.
   task automatic close_win(input logic [1:0] idle_pins, input string req);
      xfer_active = 1'b0; scl = 1'b1; sda = 1'b1; tie_pin = idle_pins;
      for (int i = 0; i < PINS; i++) begin
         if (m_fs[i] && m_hi[i] && m_lo[i] && m_split)      m_code[i] = 2'b10;
         else if (m_fd[i] && m_hi[i] && m_lo[i] && m_split) m_code[i] = 2'b11;
         else                                               m_code[i] = {1'b0, m_lv[i]};
      end
      m_resolved = 1'b1;
      model_clear();
      @(negedge clk);
      #0.5;
      check({req, " addr after close"}, addr, exp_addr());
      check({"R8 pu_en after close, ", req}, pu_en, exp_pu());
   endtask

   task automatic tied_window(input int t1, input int t0, input int len, input string req);
      logic s, d;
      for (int c = 0; c < len; c++) begin
         s = 1'($urandom % 2);
         d = 1'($urandom % 2);
         win_cycle(s, d, {pin_of(t1, s, d), pin_of(t0, s, d)});
      end
      close_win({pin_of(t1, 1'b1, 1'b1), pin_of(t0, 1'b1, 1'b1)}, req);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      model_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd7341));
      model_reset();
      tie_pin = 2'b10;
      do_reset();

      // Reset state, unresolved, pins show live levels
      check("R1 prefix after reset", addr[6:4], 3'b110);
      check("R2 live field pin1=1 pin0=0", addr, 7'h64);
      check("R8 pu_en live", pu_en, 2'b10);
      tie_pin = 2'b01; #1;
      check("R2 live field follows pin same cycle", addr, 7'h61);
      check("R8 pu_en follows live pin", pu_en, 2'b01);
      @(negedge clk);

      // R3 clock tie on pin1, supply on pin0 -> 0x69
      win_cycle(1'b1, 1'b0, 2'b11);
      win_cycle(1'b0, 1'b1, 2'b01);
      win_cycle(1'b1, 1'b1, 2'b11);
      close_win(2'b11, "R3 clock tie");
      check("R3 clock tie code", addr, 7'h69);

      // R4 data tie on pin0, ground on pin1 -> 0x63
      win_cycle(1'b1, 1'b0, 2'b00);
      win_cycle(1'b0, 1'b1, 2'b01);
      win_cycle(1'b1, 1'b1, 2'b01);
      close_win(2'b01, "R4 data tie");
      check("R4 data tie code, R7 replaced", addr, 7'h63);

      // R6 held while pins move with no window
      tie_pin = 2'b10; #1;
      check("R6 no change outside window", addr, 7'h63);
      @(negedge clk); @(negedge clk);
      check("R6 still no change", addr, 7'h63);

      // R5 last level decides: pin0 matches neither line, ends low; pin1 ends high
      win_cycle(1'b0, 1'b0, 2'b01);
      win_cycle(1'b1, 1'b1, 2'b10);
      close_win(2'b10, "R5 last level");
      check("R5 last level code", addr, 7'h64);
      check("R8 ground group disabled", pu_en, 2'b10);

      // Clock-tied pin but lines never split: level only (R3 corner)
      win_cycle(1'b1, 1'b1, 2'b10);
      win_cycle(1'b0, 1'b0, 2'b00);
      close_win(2'b10, "R3 no split corner");
      check("R3 no split gives ground", addr, 7'h60);
      check("R8 both groups off", pu_en, 2'b00);

      // Clock-tied pin with a window too short to toggle (R3 corner)
      win_cycle(1'b1, 1'b0, 2'b10);
      close_win(2'b10, "R3 no toggle corner");
      check("R3 single cycle gives supply", addr, 7'h64);

      // R9 reset returns to live behaviour
      do_reset();
      tie_pin = 2'b11; #1;
      check("R9 live after reset", addr, 7'h65);
      check("R9 pu_en live after reset", pu_en, 2'b11);
      @(negedge clk);

      // Random windows with random ties
      for (int n = 0; n < 60; n++) begin
         int t1, t0, len;
         t1 = int'($urandom % 4);
         t0 = int'($urandom % 4);
         len = (n % 4 == 0) ? 1 + int'($urandom % 2) : 2 + int'($urandom % 14);
         tied_window(t1, t0, len, "R3/R4/R5/R7 random");
         repeat (int'($urandom % 3)) begin
            check("R6 idle hold", addr, exp_addr());
            @(negedge clk);
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog R6 actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule